// File: doc/BRIEF.md
# Shared-Bus Register File

This block holds a small set of registers that exchange data over one common internal bus rather than through separate read and write ports. A control word names a source register and a destination register. The source field goes through a decoder that yields one active-low output enable per register. At most one of these is low, and the register whose enable is low is the only driver of the bus. The destination field goes through a second decoder that yields one write strobe per register. Only the strobed register takes the bus value.

A move is started with a single-cycle `start` pulse and then runs in two phases. In the settle phase the source enable is asserted and the bus value becomes stable. In the write phase the source stays selected and a one-cycle strobe goes to the destination. When no register enable is low, the bus carries the external load value. This lets an external-source move load any register from outside. A register can be read from the ports by moving it onto itself and observing the bus during the settle phase.

Top module: `shared_bus_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register to zero, drives all of `oe_n` high, drives `wr_stb` to zero, and drops `busy`.
- R2: In `instr`, bits [5:3] select the source register and bits [2:0] select the destination register. Bits [7:6] have no effect.
- R3: At most one bit of `oe_n` is low in any cycle. During a register-source move, exactly the bit that the source field indexes is low.
- R4: While the block is idle, all `oe_n` bits are high and `wr_stb` is zero.
- R5: `bus_out` equals the contents of the register whose enable is low. When no enable is low, it equals `ext_data`.
- R6: `wr_stb` is one-hot or zero. It is high only in the second cycle of a move, for exactly one cycle, on the bit that the destination field indexes.
- R7: After a move, only the destination register changes. All other registers keep their contents.
- R8: `busy` rises on the cycle after an accepted `start` and stays high for exactly two cycles.
- R9: When `ext_mode` is high at `start`, `oe_n` stays all high for the whole move, and the destination register loads `ext_data` as sampled in the write cycle.
- R10: A move whose source and destination are equal leaves that register unchanged.
- R11: A `start` that arrives while `busy` is high is ignored. The move in progress completes unchanged and no further move follows.
- R12: `oe_n` holds the same value through both phases of a move, so the source is still driving the bus when the strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a move when the block is idle |
| instr | input | 8 | Control word carrying the source and destination fields |
| ext_mode | input | 1 | Selects the external value as the move source |
| ext_data | input | 8 | External load value placed on the bus when no register drives it |
| busy | output | 1 | High during both phases of a move |
| oe_n | output | 8 | Active-low per-register bus output enables |
| wr_stb | output | 8 | Per-register write strobes |
| bus_out | output | 8 | Current value of the shared bus |

## Verification
A register that captured the wrong value, or captured when it should have held, stays hidden until a later move uses it as a source. The fault then appears on `bus_out` in the settle cycle of that move, one cycle after its `start`. A decoder or sequencer fault shows up at once on `oe_n`, `wr_stb` or `busy` in the cycle where it happens. The bench compares these outputs with its model on every clock. It also reads back every register through self-moves after the loads and moves, so that a corrupted register cannot stay hidden.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    parameter int NREG = 8;
    parameter int DW   = 8;
    parameter int IW   = 8;
    localparam int SW  = $clog2(NREG);

    typedef logic [DW-1:0] data_t;
    typedef logic [SW-1:0] sel_t;
    typedef logic [NREG-1:0] lines_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_WRITE  = 2'd2
    } phase_t;

    typedef struct packed {
        sel_t src;
        sel_t dst;
        logic ext;
    } move_t;

    function automatic sel_t src_field(input logic [IW-1:0] w);
        return w[2*SW-1:SW];
    endfunction

    function automatic sel_t dst_field(input logic [IW-1:0] w);
        return w[SW-1:0];
    endfunction
endpackage

// File: rtl/sbr_decoder.sv
module sbr_decoder
    import sbr_pkg::*;
#(
    parameter int N = NREG,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic [$clog2(N)-1:0] sel,
    input  logic                 en,
    output logic [N-1:0]         lines
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic hit;
        assign hit = en && (sel == i[$clog2(N)-1:0]);
        if (ACTIVE_LOW) begin : g_low
            assign lines[i] = ~hit;
        end else begin : g_high
            assign lines[i] = hit;
        end
    end
endmodule

// File: rtl/sbr_sequencer.sv
module sbr_sequencer
    import sbr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IW-1:0]   instr,
    input  logic            ext_mode,
    output logic            busy,
    output logic            src_drive,
    output logic            write_go,
    output sel_t            src_sel,
    output sel_t            dst_sel,
    output logic            ext_q
);
    phase_t phase_q;
    move_t  mv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mv_q    <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        mv_q.src <= src_field(instr);
                        mv_q.dst <= dst_field(instr);
                        mv_q.ext <= ext_mode;
                        phase_q  <= PH_SETTLE;
                    end
                end
                PH_SETTLE: phase_q <= PH_WRITE;
                PH_WRITE:  phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (phase_q != PH_IDLE);
        src_drive = busy && !mv_q.ext;
        write_go  = (phase_q == PH_WRITE);
        src_sel   = mv_q.src;
        dst_sel   = mv_q.dst;
        ext_q     = mv_q.ext;
    end
endmodule

// File: rtl/sbr_bank.sv
module sbr_bank
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lines_t            wr_stb,
    input  data_t             bus,
    output data_t             q [NREG]
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        data_t r_q;
        always_ff @(posedge clk) begin
            if (rst)            r_q <= '0;
            else if (wr_stb[i]) r_q <= bus;
        end
        assign q[i] = r_q;
    end
endmodule

// File: rtl/sbr_busmux.sv
module sbr_busmux
    import sbr_pkg::*;
(
    input  lines_t  oe_n,
    input  data_t   q [NREG],
    input  data_t   ext_data,
    output data_t   bus
);
    data_t terms [NREG+1];

    assign terms[0] = (&oe_n) ? ext_data : '0;
    for (genvar i = 0; i < NREG; i++) begin : g_drv
        assign terms[i+1] = terms[i] | (oe_n[i] ? '0 : q[i]);
    end
    assign bus = terms[NREG];
endmodule

// File: rtl/shared_bus_regfile.sv
module shared_bus_regfile
    import sbr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IW-1:0]   instr,
    input  logic            ext_mode,
    input  logic [DW-1:0]   ext_data,
    output logic            busy,
    output logic [NREG-1:0] oe_n,
    output logic [NREG-1:0] wr_stb,
    output logic [DW-1:0]   bus_out
);
    logic  src_drive, write_go, ext_q;
    sel_t  src_sel, dst_sel;
    data_t q [NREG];
    data_t bus;

    sbr_sequencer u_seq (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .ext_mode(ext_mode), .busy(busy), .src_drive(src_drive),
        .write_go(write_go), .src_sel(src_sel), .dst_sel(dst_sel),
        .ext_q(ext_q)
    );

    sbr_decoder #(.N(NREG), .ACTIVE_LOW(1'b1)) u_src_dec (
        .sel(src_sel), .en(src_drive), .lines(oe_n)
    );

    sbr_decoder #(.N(NREG), .ACTIVE_LOW(1'b0)) u_dst_dec (
        .sel(dst_sel), .en(write_go), .lines(wr_stb)
    );

    sbr_busmux u_mux (
        .oe_n(oe_n), .q(q), .ext_data(ext_data), .bus(bus)
    );

    sbr_bank u_bank (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .bus(bus), .q(q)
    );

    assign bus_out = bus;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
    import sbr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic [NREG-1:0] oe_n,
    input logic [NREG-1:0] wr_stb,
    input logic [DW-1:0]   bus_out,
    input logic [DW-1:0]   ext_data,
    input logic            ext_q
);
    p_one_driver_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~oe_n));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (oe_n == '1 && wr_stb == '0));

    p_undriven_ext_r5: assert property (@(posedge clk) disable iff (rst)
        (oe_n == '1) |-> (bus_out == ext_data));

    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb) |=> (wr_stb == '0));

    p_strobe_after_settle_r6: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb) |-> (busy && $past(busy)));

    p_busy_two_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 !busy);

    p_ext_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && ext_q) |-> (oe_n == '1));

    p_src_held_r12: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb) |-> $stable(oe_n));
endmodule

bind shared_bus_regfile sbr_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .oe_n(oe_n), .wr_stb(wr_stb),
    .bus_out(bus_out), .ext_data(ext_data), .ext_q(ext_q)
);

// File: tb/shared_bus_regfile_tb.sv
module shared_bus_regfile_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] instr;
    logic       ext_mode;
    logic [7:0] ext_data;
    logic       busy;
    logic [7:0] oe_n, wr_stb, bus_out;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [7:0] m_reg [8];
    int         m_phase;
    int         m_src, m_dst;
    bit         m_ext;

    always #5 clk = ~clk;

    shared_bus_regfile u_dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .ext_mode(ext_mode), .ext_data(ext_data), .busy(busy),
        .oe_n(oe_n), .wr_stb(wr_stb), .bus_out(bus_out)
    );

    function automatic logic [7:0] val_of(input int i);
        return 8'(8'h1F + i * 8'h23);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model advances on each clock
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (start) begin
                       m_src = int'(instr[5:3]);
                       m_dst = int'(instr[2:0]);
                       m_ext = ext_mode;
                       m_phase = 1;
                   end
                1: m_phase = 2;
                default: begin
                    m_reg[m_dst] = m_ext ? ext_data : m_reg[m_src];
                    m_phase = 0;
                end
            endcase
        end
    end

    // compare outputs every cycle, away from the edge
    always @(negedge clk) begin
        #2;
        if (!rst && m_phase >= 0) begin
            logic [7:0] e_oe, e_wr, e_bus;
            e_oe = 8'hFF;
            e_wr = 8'h00;
            if (m_phase != 0 && !m_ext) e_oe[m_src] = 1'b0;
            if (m_phase == 2) e_wr[m_dst] = 1'b1;
            e_bus = (e_oe == 8'hFF) ? ext_data : m_reg[m_src];
            chk("R8 busy", {7'd0, busy}, {7'd0, m_phase != 0});
            chk("R3 oe_n", oe_n, e_oe);
            chk("R6 wr_stb", wr_stb, e_wr);
            chk("R5 bus_out", bus_out, e_bus);
        end
    end

    // runs one move; returns the bus value seen in the settle cycle
    task automatic move(input int src, input int dst, input bit ext,
                        input logic [7:0] data, output logic [7:0] seen);
        @(negedge clk);
        start    = 1'b1;
        instr    = {2'b10, 3'(src), 3'(dst)};
        ext_mode = ext;
        ext_data = data;
        @(negedge clk);
        start = 1'b0;
        #2 seen = bus_out;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input int idx, input logic [7:0] exp, input string tag);
        logic [7:0] s;
        move(idx, idx, 1'b0, 8'hA5, s);
        chk(tag, s, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s;
        m_phase = 0; m_src = 0; m_dst = 0; m_ext = 0;
        rst = 1'b1; start = 1'b0; instr = '0; ext_mode = 1'b0; ext_data = 8'h3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: state after reset
        chk("R1 busy", {7'd0, busy}, 8'd0);
        chk("R1 oe_n", oe_n, 8'hFF);
        chk("R1 wr_stb", wr_stb, 8'h00);
        chk("R4 idle bus", bus_out, 8'h3C);
        read_reg(3, 8'h00, "R1 reg cleared");

        // R9: external loads
        for (int i = 0; i < 8; i++) move(0, i, 1'b1, val_of(i), s);
        for (int i = 0; i < 8; i++) read_reg(i, val_of(i), "R9 ext load");
        // R10: self moves kept values
        read_reg(6, val_of(6), "R10 self move");

        // R2, R7: register move r2 -> r5
        move(2, 5, 1'b0, 8'h00, s);
        chk("R2 settle bus shows src", s, val_of(2));
        read_reg(5, val_of(2), "R2 dst got src");
        read_reg(2, val_of(2), "R7 src kept");
        read_reg(4, val_of(4), "R7 other kept");

        // R11: start held during busy
        @(negedge clk);
        start = 1'b1; instr = {2'b00, 3'd7, 3'd0}; ext_mode = 1'b0;
        @(negedge clk);
        instr = {2'b00, 3'd1, 3'd3};
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        #2 chk("R11 idle after one move", {7'd0, busy}, 8'd0);
        read_reg(0, val_of(7), "R11 first move done");
        read_reg(3, val_of(3), "R11 second start ignored");

        // R12/R6: external move with changing idle data
        move(0, 1, 1'b1, 8'h99, s);
        chk("R9 ext on bus", s, 8'h99);
        read_reg(1, 8'h99, "R9 ext dst");

        // R1 again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_reg(0, 8'h00, "R1 second reset");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule